// File: doc/BRIEF.md
# Scoreboard-Checked Dispatch Station

This block holds a small pool of decoded instructions waiting for their source registers. It also owns the register file and a one-bit-per-register availability map. An instruction that is accepted at issue goes into a free slot. At the same time, the availability bit of its destination register drops to 0. The slot stores only the opcode and the three register numbers. It keeps no flag that says whether an operand is ready.

Every cycle the block looks up the availability bits of each occupied slot's two source registers. Of the slots whose sources are both available, it sends the lowest-numbered one to the execution unit, and it reads that slot's operand values from the register file at that moment. A result returned by the execution unit writes the register file and raises the register's availability bit. The returned result is also visible to the dispatch check and to the operand read in the cycle it arrives.

Top module: `sb_dispatch_station`

## Requirements
- R1: After reset every register is marked available, all slots are empty, `iss_ready` is 1, `disp_valid` is 0, and every register reads 0.
- R2: An accepted issue (`iss_valid` and `iss_ready` both 1) clears the availability bit of `iss_dst` from the next cycle on. A later instruction that reads that register does not dispatch while the bit is 0.
- R3: A writeback (`wb_valid`) stores `wb_data` into register `wb_reg` and sets its availability bit. Instructions issued afterwards read the stored value.
- R4: A slot dispatches only when the availability bits of both of its source registers are 1. The choice depends on readiness and not on issue age.
- R5: While `disp_valid` is 1, `disp_op` and `disp_dst` are the chosen slot's opcode and destination. `disp_opnd_a` and `disp_opnd_b` are the register contents of its first and second source, read in the dispatch cycle.
- R6: When several slots are ready, the one with the lowest slot index dispatches. At most one slot dispatches per cycle.
- R7: A writeback counts toward the dispatch check in the same cycle. A slot waiting only on `wb_reg` dispatches in that cycle, with `wb_data` as that operand.
- R8: With all slots occupied, `iss_ready` is 0, and an `iss_valid` in that state stores nothing and clears no availability bit.
- R9: When an accepted issue and a writeback name the same register in one cycle, the bit ends at 0.
- R10: A dispatched slot is empty from the next cycle. Issue fills the lowest-numbered empty slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Decoded instruction offered for issue |
| iss_ready | output | 1 | A slot is free; issue is accepted |
| iss_op | input | OPW | Opcode of the offered instruction |
| iss_src_a | input | log2(NREG) | First source register number |
| iss_src_b | input | log2(NREG) | Second source register number |
| iss_dst | input | log2(NREG) | Destination register number |
| disp_valid | output | 1 | A slot is sent to the execution unit this cycle |
| disp_op | output | OPW | Opcode of the dispatched slot |
| disp_dst | output | log2(NREG) | Destination of the dispatched slot |
| disp_opnd_a | output | DW | Value of the first source register |
| disp_opnd_b | output | DW | Value of the second source register |
| wb_valid | input | 1 | Result returned by the execution unit |
| wb_reg | input | log2(NREG) | Register the result is written to |
| wb_data | input | DW | Result value |

## Verification
The dispatch check is exercised in four situations: sources available at issue, sources pending until a later writeback, several slots waiting on one register, and an older stalled slot beside a younger ready one. These separate a station that reads readiness at dispatch from one that latches it at issue. They also separate lowest-index selection from oldest-first selection. Writebacks arrive in the very cycle a slot is waiting, and the operand values returned show whether the bypass and the late operand read work. A full station fed an extra instruction, and an issue and a writeback on the same register, check the stall and the clear-wins rule.

// File: rtl/sb_dispatch_station.sv
module sb_dispatch_station #(
  parameter int NREG = 16,
  parameter int NENT = 4,
  parameter int DW   = 32,
  parameter int OPW  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_valid,
  output logic                    iss_ready,
  input  logic [OPW-1:0]          iss_op,
  input  logic [$clog2(NREG)-1:0] iss_src_a,
  input  logic [$clog2(NREG)-1:0] iss_src_b,
  input  logic [$clog2(NREG)-1:0] iss_dst,
  output logic                    disp_valid,
  output logic [OPW-1:0]          disp_op,
  output logic [$clog2(NREG)-1:0] disp_dst,
  output logic [DW-1:0]           disp_opnd_a,
  output logic [DW-1:0]           disp_opnd_b,
  input  logic                    wb_valid,
  input  logic [$clog2(NREG)-1:0] wb_reg,
  input  logic [DW-1:0]           wb_data
);
  localparam int RW = $clog2(NREG);
  localparam int EW = (NENT > 1) ? $clog2(NENT) : 1;

  logic [NREG-1:0] sb;
  logic [DW-1:0]   rf [NREG];
  logic [NENT-1:0] occ;
  logic [OPW-1:0]  e_op  [NENT];
  logic [RW-1:0]   e_sa  [NENT];
  logic [RW-1:0]   e_sb  [NENT];
  logic [RW-1:0]   e_dst [NENT];

  logic [NREG-1:0] wb_oh, sbx;
  logic [NENT-1:0] rdy, disp_oh, ins_oh;
  logic [EW-1:0]   disp_sel;
  logic            iss_fire;

  assign wb_oh     = {{(NREG-1){1'b0}}, wb_valid} << wb_reg;
  assign sbx       = sb | wb_oh;
  assign iss_ready = ~&occ;
  assign iss_fire  = iss_valid & iss_ready;

  for (genvar g = 0; g < NENT; g++) begin : g_rdy
    assign rdy[g] = occ[g] & sbx[e_sa[g]] & sbx[e_sb[g]];
  end

  always_comb begin
    disp_sel = '0;
    disp_oh  = '0;
    ins_oh   = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (rdy[i]) begin
        disp_sel = EW'(i);
        disp_oh  = NENT'(1) << i;
      end
      if (!occ[i] && iss_fire) ins_oh = NENT'(1) << i;
    end
  end

  assign disp_valid  = |rdy;
  assign disp_op     = e_op[disp_sel];
  assign disp_dst    = e_dst[disp_sel];
  assign disp_opnd_a = (wb_valid && wb_reg == e_sa[disp_sel]) ? wb_data : rf[e_sa[disp_sel]];
  assign disp_opnd_b = (wb_valid && wb_reg == e_sb[disp_sel]) ? wb_data : rf[e_sb[disp_sel]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sb  <= '1;
      occ <= '0;
      for (int r = 0; r < NREG; r++) rf[r] <= '0;
    end else begin
      if (wb_valid) begin
        sb[wb_reg] <= 1'b1;
        rf[wb_reg] <= wb_data;
      end
      if (iss_fire) sb[iss_dst] <= 1'b0;
      occ <= (occ & ~disp_oh) | ins_oh;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NENT; i++) begin
      if (ins_oh[i]) begin
        e_op[i]  <= iss_op;
        e_sa[i]  <= iss_src_a;
        e_sb[i]  <= iss_src_b;
        e_dst[i] <= iss_dst;
      end
    end
  end
endmodule

// File: rtl/sb_dispatch_station_chk.sv
module sb_dispatch_station_chk #(
  parameter int NREG = 16,
  parameter int NENT = 4,
  parameter int DW   = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    iss_valid,
  input logic                    iss_ready,
  input logic [$clog2(NREG)-1:0] iss_dst,
  input logic                    wb_valid,
  input logic [$clog2(NREG)-1:0] wb_reg,
  input logic [DW-1:0]           wb_data,
  input logic                    disp_valid,
  input logic [NREG-1:0]         sb,
  input logic [DW-1:0]           rf [NREG],
  input logic [NENT-1:0]         occ,
  input logic [NENT-1:0]         disp_oh
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&sb && occ == '0)); // R1
  AST_ISSUE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> !sb[$past(iss_dst)]); // R2
  AST_WB_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(iss_valid && iss_ready && iss_dst == wb_reg)) |=> sb[$past(wb_reg)]); // R3
  AST_WB_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> rf[$past(wb_reg)] == $past(wb_data)); // R3
  AST_ONE_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(disp_oh)); // R6
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(occ) == NENT) |-> !iss_ready); // R8
  AST_SLOT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(occ) == $past($countones(occ)) + int'($past(iss_valid && iss_ready))
                                 - int'($past(disp_valid)))); // R10
endmodule

bind sb_dispatch_station sb_dispatch_station_chk #(.NREG(NREG), .NENT(NENT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_dst(iss_dst),
  .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data), .disp_valid(disp_valid),
  .sb(sb), .rf(rf), .occ(occ), .disp_oh(disp_oh)
);

// File: tb/test_sb_dispatch_station.sv
module test_sb_dispatch_station;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iss_valid = 1'b0, wb_valid = 1'b0;
  logic       iss_ready, disp_valid;
  logic [5:0] iss_op = '0, disp_op;
  logic [3:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0, disp_dst, wb_reg = '0;
  logic [31:0] disp_opnd_a, disp_opnd_b, wb_data = '0;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sb_dispatch_station i_sb_dispatch_station (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst), .disp_valid(disp_valid),
    .disp_op(disp_op), .disp_dst(disp_dst), .disp_opnd_a(disp_opnd_a), .disp_opnd_b(disp_opnd_b),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    iss_valid = 1'b0;
    wb_valid  = 1'b0;
  endtask

  task automatic issue(input int op, input int a, input int b, input int d);
    iss_valid = 1'b1; iss_op = 6'(op); iss_src_a = 4'(a); iss_src_b = 4'(b); iss_dst = 4'(d);
  endtask

  task automatic wb(input int r, input int v);
    wb_valid = 1'b1; wb_reg = 4'(r); wb_data = 32'(v);
  endtask

  task automatic exp_disp(input string req, input int op, input int a, input int b, input int d);
    chk(req, "disp_valid", 32'(disp_valid), 32'd1);
    chk(req, "disp_op", 32'(disp_op), 32'(op));
    chk(req, "disp_opnd_a", disp_opnd_a, 32'(a));
    chk(req, "disp_opnd_b", disp_opnd_b, 32'(b));
    chk(req, "disp_dst", 32'(disp_dst), 32'(d));
  endtask

  task automatic exp_none(input string req);
    chk(req, "disp_valid", 32'(disp_valid), 32'd0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "iss_ready", 32'(iss_ready), 32'd1);
    exp_none("R1");
    cyc(); issue(2, 7, 8, 0); #1 exp_none("R1");
    cyc(); #1 exp_disp("R1", 2, 0, 0, 0);
    cyc(); #1 exp_none("R10");
  endtask

  task automatic t_load();
    cyc(); wb(1, 11);
    cyc(); wb(2, 22);
    cyc(); wb(5, 55);
    cyc(); wb(0, 0);
  endtask

  task automatic t_basic();
    cyc(); issue(3, 1, 2, 4);
    cyc(); #1 exp_disp("R5", 3, 11, 22, 4);
    cyc(); #1 exp_none("R10");
  endtask

  task automatic t_dep();
    cyc(); issue(5, 4, 1, 6);
    cyc(); #1 exp_none("R2");
    cyc(); #1 exp_none("R2");
    cyc(); wb(4, 44); #1 exp_disp("R7", 5, 44, 11, 6);
    cyc(); #1 exp_none("R10");
    cyc(); issue(7, 4, 4, 8);
    cyc(); #1 exp_disp("R3", 7, 44, 44, 8);
  endtask

  task automatic t_prio();
    cyc(); issue(1, 1, 1, 9);
    cyc(); #1 exp_disp("R4", 1, 11, 11, 9);
    cyc(); issue(10, 9, 1, 10);
    cyc(); issue(11, 9, 2, 11); #1 exp_none("R2");
    cyc(); issue(12, 1, 9, 12); #1 exp_none("R2");
    cyc(); #1 exp_none("R4");
    cyc(); wb(9, 99); #1 exp_disp("R6", 10, 99, 11, 10);
    cyc(); #1 exp_disp("R6", 11, 99, 22, 11);
    cyc(); #1 exp_disp("R6", 12, 11, 99, 12);
    cyc(); #1 exp_none("R6");
  endtask

  task automatic t_order();
    cyc(); issue(15, 10, 1, 3);
    cyc(); issue(16, 1, 2, 5); #1 exp_none("R4");
    cyc(); #1 exp_disp("R4", 16, 11, 22, 5);
    cyc(); #1 exp_none("R4");
    cyc(); wb(10, 100); #1 exp_disp("R7", 15, 100, 11, 3);
    cyc(); #1 exp_none("R10");
    cyc(); wb(3, 30);
    cyc(); wb(5, 50);
  endtask

  task automatic t_full();
    cyc(); issue(20, 1, 1, 13);
    cyc(); #1 exp_disp("R4", 20, 11, 11, 13);
    cyc(); issue(21, 13, 1, 14); #1 chk("R8", "iss_ready", 32'(iss_ready), 32'd1);
    cyc(); issue(22, 13, 1, 15);
    cyc(); issue(23, 13, 1, 14);
    cyc(); issue(24, 13, 1, 15);
    cyc(); #1 chk("R8", "iss_ready full", 32'(iss_ready), 32'd0);
    exp_none("R8");
    issue(30, 1, 1, 2);
    cyc(); #1 exp_none("R8");
    chk("R8", "iss_ready still full", 32'(iss_ready), 32'd0);
    wb(13, 7); #1 exp_disp("R7", 21, 7, 11, 14);
    cyc(); #1 chk("R10", "iss_ready after free", 32'(iss_ready), 32'd1);
    exp_disp("R6", 22, 7, 11, 15);
    cyc(); #1 exp_disp("R6", 23, 7, 11, 14);
    cyc(); #1 exp_disp("R6", 24, 7, 11, 15);
    cyc(); #1 exp_none("R8");
    cyc(); issue(31, 2, 2, 0);
    cyc(); #1 exp_disp("R8", 31, 22, 22, 0);
  endtask

  task automatic t_clash();
    cyc(); issue(40, 1, 1, 3); wb(3, 33);
    cyc(); #1 exp_disp("R9", 40, 11, 11, 3);
    cyc(); issue(41, 3, 1, 5);
    cyc(); #1 exp_none("R9");
    cyc(); #1 exp_none("R9");
    cyc(); wb(3, 34); #1 exp_disp("R9", 41, 34, 11, 5);
    cyc(); #1 exp_none("R10");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_load();
    t_basic();
    t_dep();
    t_prio();
    t_order();
    t_full();
    t_clash();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule